// File: doc/BRIEF.md
# Address-Decoding Bus Demultiplexer

This block sits between one master and several slaves on a simple request/grant memory bus. Each slave port owns a window of the 32-bit address space, given by a base and a mask parameter. The master's request is steered to the single port whose window holds the address. That port's grant goes back to the master. Later, its read response goes back the same way.

At most one read may be in flight. Once a read is accepted, every slave sees its request held low. The master sees no grant until the owning slave returns its read data. If an address falls in no window, the block signals an illegal access for as long as that request is held. No slave is disturbed by such a request.

Top module: `addr_demux`

## Requirements
- R1: Port i matches when `(m_addr_i & MASK_i) == BASE_i`. When idle, `s_req_o` has exactly the bit of the matching port set, and zero otherwise. BASE_i and MASK_i are bits `[32*i +: 32]` of `PORT_BASE` and `PORT_MASK`.
- R2: When several ports match, the lowest index is selected. With the defaults, port 2 (base 0x0000_0000, mask 0xF000_0000) overlaps ports 0 (0x0000_0000/0xFFFF_0000) and 1 (0x0001_0000/0xFFFF_0000).
- R3: Every slave port carries the master's address, write enable, byte enables and write data, in slice `[32*i +: 32]` (or `[4*i +: 4]` for byte enables, bit i for write enable).
- R4: `m_gnt_o` equals the grant of the selected slave while a mapped request is forwarded. A transfer is accepted on a rising edge with request and grant both high.
- R5: After a read is accepted, `s_req_o` is all zero and `m_gnt_o` is low, up to and including the edge where the owning slave's `s_rvalid_i` is high. Accepted writes do not block later requests.
- R6: `m_rvalid_o` and `m_rdata_o` come only from the port that accepted the outstanding read. The `s_rvalid_i` bits of other ports are ignored.
- R7: A read completes on the first edge its owning port's `s_rvalid_i` is high. `m_rvalid_o` is high for that one cycle only, even if the slave holds its valid longer. Requests are forwarded again in the next cycle.
- R8: For an unmapped request, `illegal_access_o` is high while the request is held. In that case `s_req_o` is zero and `m_gnt_o` is low. The flag is low when no request is present.
- R9: After reset no read is outstanding: `s_req_o` follows decoding and `m_rvalid_o` is low.
- R10: `s_rvalid_i` with no outstanding read does not reach the master. `m_rdata_o` is zero whenever `m_rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m_req_i | input | 1 | Master request |
| m_gnt_o | output | 1 | Grant to master |
| m_addr_i | input | 32 | Master address |
| m_we_i | input | 1 | Master write enable |
| m_be_i | input | 4 | Master byte enables |
| m_wdata_i | input | 32 | Master write data |
| m_rvalid_o | output | 1 | Read data valid to master |
| m_rdata_o | output | 32 | Read data to master |
| illegal_access_o | output | 1 | Request address maps to no port |
| s_req_o | output | N | Per-slave request |
| s_gnt_i | input | N | Per-slave grant |
| s_addr_o | output | 32*N | Per-slave address |
| s_we_o | output | N | Per-slave write enable |
| s_be_o | output | 4*N | Per-slave byte enables |
| s_wdata_o | output | 32*N | Per-slave write data |
| s_rvalid_i | input | N | Per-slave read valid |
| s_rdata_i | input | 32*N | Per-slave read data |

## Verification
The block holds two pieces of state: an outstanding-read flag and the index of the port that owns the read. If the flag is wrong, it shows at once at the ports. A stuck flag blocks every request, so the grant never returns. A flag that is never set lets a second request through in the very next cycle after a read is accepted. A wrong owner index shows on the completion cycle. Either the wrong port's data appears, or the read never completes, so the bench holds a noise valid on a second port during each read.

// File: rtl/addr_demux.sv
module addr_demux #(
  parameter int N = 3,
  parameter logic [32*N-1:0] PORT_BASE = {32'h0000_0000, 32'h0001_0000, 32'h0000_0000},
  parameter logic [32*N-1:0] PORT_MASK = {32'hF000_0000, 32'hFFFF_0000, 32'hFFFF_0000}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            m_req_i,
  output logic            m_gnt_o,
  input  logic [31:0]     m_addr_i,
  input  logic            m_we_i,
  input  logic [3:0]      m_be_i,
  input  logic [31:0]     m_wdata_i,
  output logic            m_rvalid_o,
  output logic [31:0]     m_rdata_o,
  output logic            illegal_access_o,
  output logic [N-1:0]    s_req_o,
  input  logic [N-1:0]    s_gnt_i,
  output logic [32*N-1:0] s_addr_o,
  output logic [N-1:0]    s_we_o,
  output logic [4*N-1:0]  s_be_o,
  output logic [32*N-1:0] s_wdata_o,
  input  logic [N-1:0]    s_rvalid_i,
  input  logic [32*N-1:0] s_rdata_i
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  hit;
  logic [31:0]   rd_arr [N];
  logic [IW-1:0] sel_idx, own_q;
  logic          hit_any, busy_q, fwd, done;

  for (genvar i = 0; i < N; i++) begin : g_port
    assign hit[i]    = (m_addr_i & PORT_MASK[32*i +: 32]) == PORT_BASE[32*i +: 32];
    assign rd_arr[i] = s_rdata_i[32*i +: 32];
  end

  always_comb begin
    sel_idx = '0;
    hit_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_idx = IW'(i);
        hit_any = 1'b1;
      end
    end
  end

  assign fwd  = m_req_i && hit_any && !busy_q;
  assign done = busy_q && s_rvalid_i[own_q];

  assign s_req_o          = fwd ? (N'(1) << sel_idx) : '0;
  assign m_gnt_o          = fwd && s_gnt_i[sel_idx];
  assign illegal_access_o = m_req_i && !hit_any;
  assign m_rvalid_o       = done;
  assign m_rdata_o        = done ? rd_arr[own_q] : '0;

  assign s_addr_o  = {N{m_addr_i}};
  assign s_we_o    = {N{m_we_i}};
  assign s_be_o    = {N{m_be_i}};
  assign s_wdata_o = {N{m_wdata_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      own_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (m_gnt_o && !m_we_i) begin
      busy_q <= 1'b1;
      own_q  <= sel_idx;
    end
  end
endmodule

// File: rtl/addr_demux_props.sv
module addr_demux_props #(
  parameter int N = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         m_req_i,
  input logic         m_gnt_o,
  input logic         m_we_i,
  input logic         m_rvalid_o,
  input logic [31:0]  m_rdata_o,
  input logic         illegal_access_o,
  input logic [N-1:0] s_req_o,
  input logic [N-1:0] s_gnt_i
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (pend_q) pend_q <= !m_rvalid_o;
    else             pend_q <= m_req_i && m_gnt_o && !m_we_i;
  end

  p_onehot_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_req_o));

  p_gnt_from_slave_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_gnt_o |-> m_req_i && ((s_gnt_i & s_req_o) != '0));

  p_block_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (s_req_o == '0) && !m_gnt_o);

  p_rvalid_owned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rvalid_o |-> pend_q);

  p_single_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rvalid_o |=> !m_rvalid_o);

  p_illegal_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_access_o |-> (s_req_o == '0) && !m_gnt_o && m_req_i);

  p_rdata_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_rvalid_o |-> m_rdata_o == '0);
endmodule

bind addr_demux addr_demux_props #(.N(N)) u_props (
  .clk_i(clk_i), .rst_ni(rst_ni), .m_req_i(m_req_i), .m_gnt_o(m_gnt_o),
  .m_we_i(m_we_i), .m_rvalid_o(m_rvalid_o), .m_rdata_o(m_rdata_o),
  .illegal_access_o(illegal_access_o), .s_req_o(s_req_o), .s_gnt_i(s_gnt_i)
);

// File: tb/addr_demux_test.sv
`timescale 1ns/1ps
module addr_demux_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [3:0]  m_be = '0;
  logic [2:0]  s_gnt = '0, s_rvalid = '0;
  logic [95:0] s_rdata = '0;
  logic        m_gnt_o, m_rvalid_o, illegal_access_o;
  logic [31:0] m_rdata_o;
  logic [2:0]  s_req_o, s_we_o;
  logic [95:0] s_addr_o, s_wdata_o;
  logic [11:0] s_be_o;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  addr_demux uut (
    .clk_i(clk), .rst_ni(rst_ni), .m_req_i(m_req), .m_gnt_o(m_gnt_o),
    .m_addr_i(m_addr), .m_we_i(m_we), .m_be_i(m_be), .m_wdata_i(m_wdata),
    .m_rvalid_o(m_rvalid_o), .m_rdata_o(m_rdata_o), .illegal_access_o(illegal_access_o),
    .s_req_o(s_req_o), .s_gnt_i(s_gnt), .s_addr_o(s_addr_o), .s_we_o(s_we_o),
    .s_be_o(s_be_o), .s_wdata_o(s_wdata_o), .s_rvalid_i(s_rvalid), .s_rdata_i(s_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_ni && m_rvalid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected rvalid", m_rdata_o, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        check(m_rdata_o == e, "R6 read data", m_rdata_o, e);
      end
    end
  end

  task automatic read_txn(input logic [31:0] a, input int p, input logic [31:0] d, input int wait_cycles);
    automatic int q = (p + 1) % 3;
    @(negedge clk);
    m_req = 1'b1; m_addr = a; m_we = 1'b0; m_be = 4'hF; s_gnt = '0;
    for (int k = 0; k < wait_cycles; k++) begin
      #1 check(s_req_o == 3'(1 << p), "R1 decode while waiting", 32'(s_req_o), 32'(1 << p));
      check(m_gnt_o == 1'b0, "R4 no grant from slave", 32'(m_gnt_o), 0);
      @(negedge clk);
    end
    s_gnt[p] = 1'b1;
    #1 check(s_req_o == 3'(1 << p), "R2 selected port", 32'(s_req_o), 32'(1 << p));
    check(m_gnt_o == 1'b1, "R4 grant passes", 32'(m_gnt_o), 1);
    @(negedge clk);
    m_addr = 32'h0500_0010; s_gnt = '1;
    #1 check(s_req_o == '0, "R5 blocked after read", 32'(s_req_o), 0);
    check(m_gnt_o == 1'b0, "R5 no grant while pending", 32'(m_gnt_o), 0);
    @(negedge clk);
    s_rvalid[q] = 1'b1; s_rdata[32*q +: 32] = ~d;
    #1 check(m_rvalid_o == 1'b0, "R6 foreign rvalid ignored", 32'(m_rvalid_o), 0);
    @(negedge clk);
    s_rvalid[q] = 1'b0;
    exp_q.push_back(d);
    s_rvalid[p] = 1'b1; s_rdata[32*p +: 32] = d;
    #1 check(s_req_o == '0, "R5 blocked on completion cycle", 32'(s_req_o), 0);
    @(negedge clk);
    s_gnt = '0;
    #1 check(m_rvalid_o == 1'b0, "R7 single beat", 32'(m_rvalid_o), 0);
    check(s_req_o == 3'b100, "R7 forwarding resumes", 32'(s_req_o), 32'h4);
    @(negedge clk);
    m_req = 1'b0; s_rvalid = '0; s_rdata = '0;
  endtask

  task automatic write_txn(input logic [31:0] a, input int p, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    m_req = 1'b1; m_addr = a; m_we = 1'b1; m_be = be; m_wdata = d; s_gnt = '0; s_gnt[p] = 1'b1;
    #1 check(m_gnt_o == 1'b1, "R4 write grant", 32'(m_gnt_o), 1);
    check(s_req_o == 3'(1 << p), "R1 write decode", 32'(s_req_o), 32'(1 << p));
    for (int k = 0; k < 3; k++) begin
      check(s_addr_o[32*k +: 32] == a, "R3 addr mirror", s_addr_o[32*k +: 32], a);
      check(s_wdata_o[32*k +: 32] == d, "R3 wdata mirror", s_wdata_o[32*k +: 32], d);
      check(s_be_o[4*k +: 4] == be && s_we_o[k], "R3 be/we mirror", 32'({s_we_o[k], s_be_o[4*k +: 4]}), 32'({1'b1, be}));
    end
    @(negedge clk);
    m_addr = 32'h0000_0100; m_we = 1'b0; s_gnt = '0;
    #1 check(s_req_o == 3'b001, "R5 write does not block", 32'(s_req_o), 1);
    @(negedge clk);
    m_req = 1'b0;
  endtask

  initial begin
    m_req = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(s_req_o == '0 && !m_rvalid_o, "R9 reset state", 32'({m_rvalid_o, s_req_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    m_req = 1'b1; m_addr = 32'h0001_0004;
    #1 check(s_req_o == 3'b010, "R9 decode after reset", 32'(s_req_o), 2);
    @(negedge clk); m_req = 1'b0;

    read_txn(32'h0000_0040, 0, 32'hCAFE_0001, 0);
    read_txn(32'h0001_0008, 1, 32'h1234_5678, 2);
    read_txn(32'h0500_0000, 2, 32'hA5A5_5A5A, 1);
    write_txn(32'h0001_00F0, 1, 32'hDEAD_BEEF, 4'b0101);
    write_txn(32'h0700_0000, 2, 32'h0BAD_F00D, 4'b1000);

    @(negedge clk);
    m_req = 1'b1; m_addr = 32'h2000_0000; s_gnt = '1;
    for (int k = 0; k < 3; k++) begin
      #1 check(illegal_access_o == 1'b1, "R8 flag held", 32'(illegal_access_o), 1);
      check(s_req_o == '0 && !m_gnt_o, "R8 nothing forwarded", 32'({m_gnt_o, s_req_o}), 0);
      @(negedge clk);
    end
    m_req = 1'b0; s_gnt = '0;
    #1 check(illegal_access_o == 1'b0, "R8 flag drops", 32'(illegal_access_o), 0);

    @(negedge clk);
    s_rvalid = 3'b010; s_rdata[63:32] = 32'h7777_7777;
    #1 check(!m_rvalid_o && m_rdata_o == '0, "R10 stray rvalid ignored", m_rdata_o, 0);
    @(negedge clk);
    s_rvalid = '0; s_rdata = '0;
    m_req = 1'b1; m_addr = 32'h0000_0020;
    #1 check(s_req_o == 3'b001, "R10 no pending after stray", 32'(s_req_o), 1);
    @(negedge clk); m_req = 1'b0;

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule